// File: doc/BRIEF.md
# Configurable Request/Acknowledge Handshake Pair

This block joins a requesting side and an answering side through one request wire and one acknowledge wire, all in a single clock domain. A word of generic width goes with each request and the answering side captures it. The requesting side starts a transfer when it sees a `start_i` pulse and reports the end of the transfer with a one-cycle `done_o` pulse. The answering side does not acknowledge until its `slv_ready_i` input is high, so a slow receiver can hold off the exchange.

A two-bit mode input chooses how strictly the two wires are coupled. In open mode the request is withdrawn after a fixed hold time, whether or not an answer came. In half-locked mode the request stays up until the acknowledge is seen, and the acknowledge drops on its own timer. In locked mode each side waits for the other's edge before it releases its own wire. The requester takes the mode when it accepts a start and passes that mode to the answering side, so a change on the input during a transfer has no effect on it.

Top module: `hs_link`

## Requirements
- R1: After reset, `req_o`, `ack_o`, `done_o`, `busy_o` and `rx_valid_o` are all low.
- R2: A `start_i` pulse is accepted only when the requester is idle and `ack_o` is low. An accepted start raises `req_o` on the next edge. A start that arrives at any other time is dropped and does not raise `req_o` later.
- R3: In open mode (mode code 0), `req_o` stays high for exactly REQ_HOLD cycles and then falls, whether or not `ack_o` has risen. `done_o` pulses in the cycle in which `req_o` falls.
- R4: In half-locked mode (code 1) and locked mode (codes 2 and 3), `req_o` stays high until `ack_o` is seen high. It falls in the cycle after the one in which `ack_o` rises.
- R5: The answering side raises `ack_o` in the cycle after it samples `req_o` and `slv_ready_i` both high. In that same cycle it loads `rx_data_o` with the requester's word and pulses `rx_valid_o` for one cycle. In open mode, if `req_o` has already fallen by then, no acknowledge is given.
- R6: In open and half-locked modes, `ack_o` stays high for exactly ACK_HOLD cycles and then falls without waiting for `req_o`. A new request is not acknowledged until `req_o` has been seen low.
- R7: In locked mode, `ack_o` stays high until `req_o` is seen low and falls in the following cycle.
- R8: `done_o` is a single-cycle pulse, one per accepted start. In half-locked mode it comes with the fall of `req_o`. In locked mode it comes in the cycle after `ack_o` falls.
- R9: Mode code 3 behaves exactly as code 2. The mode is sampled only when a start is accepted, so changes to `mode_i` during a transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Coupling mode: 0 open, 1 half-locked, 2 or 3 locked |
| start_i | input | 1 | Start pulse for a transfer |
| tx_data_i | input | DATA_W | Word sent with the request |
| busy_o | output | 1 | Requester is in the middle of a transfer |
| done_o | output | 1 | One-cycle transfer-complete pulse |
| slv_ready_i | input | 1 | Answering side is able to accept a word |
| rx_data_o | output | DATA_W | Word captured by the answering side |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_data_o` is loaded |
| req_o | output | 1 | Request wire, observable |
| ack_o | output | 1 | Acknowledge wire, observable |

## Verification
The bench builds the block with DATA_W=8, REQ_HOLD=3 and ACK_HOLD=4. It sweeps all four mode codes against receiver-ready delays of 0 to 4 cycles. Because these delays straddle REQ_HOLD, open mode is driven both into an acknowledged transfer and into a request that expires unanswered. Because ACK_HOLD exceeds REQ_HOLD, the acknowledge is still high when an open-mode transfer completes, which exposes a start that must be dropped. One locked transfer has its mode input changed and a second start applied partway through.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        HS_OPEN    = 2'd0,
        HS_HALF    = 2'd1,
        HS_LOCKED  = 2'd2,
        HS_LOCKED2 = 2'd3
    } hs_mode_e;

    typedef enum logic [1:0] {
        HM_IDLE  = 2'd0,
        HM_REQ   = 2'd1,
        HM_DRAIN = 2'd2
    } hm_state_e;

    typedef enum logic [1:0] {
        HA_IDLE  = 2'd0,
        HA_ACK   = 2'd1,
        HA_REARM = 2'd2
    } ha_state_e;

    // What a given mode asks of each side
    typedef struct packed {
        logic waits_ack;     // requester holds req until ack is seen
        logic waits_release; // both sides wait for the opposite falling edge
    } hs_policy_t;

    function automatic hs_policy_t hs_policy(input logic [1:0] mode);
        hs_policy_t p;
        p.waits_ack     = (mode != HS_OPEN);
        p.waits_release = mode[1];
        return p;
    endfunction

endpackage

// File: rtl/hs_hold_timer.sv
module hs_hold_timer #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt;

    assign expire_o = run_i && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || expire_o) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hs_master.sv
module hs_master
    import hs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int REQ_HOLD = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        mode_o,
    output logic              busy_o,
    output logic              done_o
);
    hm_state_e  state;
    hs_policy_t pol;
    logic       tmr_run;
    logic       tmr_expire;

    assign pol     = hs_policy(mode_o);
    assign tmr_run = (state == HM_REQ) && !pol.waits_ack;
    assign busy_o  = (state != HM_IDLE);

    hs_hold_timer #(.HOLD(REQ_HOLD)) u_req_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (tmr_run),
        .expire_o (tmr_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= HM_IDLE;
            req_o  <= 1'b0;
            done_o <= 1'b0;
            data_o <= '0;
            mode_o <= HS_OPEN;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                HM_IDLE: begin
                    if (start_i && !ack_i) begin
                        mode_o <= mode_i;
                        data_o <= data_i;
                        req_o  <= 1'b1;
                        state  <= HM_REQ;
                    end
                end
                HM_REQ: begin
                    if (pol.waits_ack) begin
                        if (ack_i) begin
                            req_o <= 1'b0;
                            if (pol.waits_release) begin
                                state <= HM_DRAIN;
                            end else begin
                                done_o <= 1'b1;
                                state  <= HM_IDLE;
                            end
                        end
                    end else if (tmr_expire) begin
                        req_o  <= 1'b0;
                        done_o <= 1'b1;
                        state  <= HM_IDLE;
                    end
                end
                HM_DRAIN: begin
                    if (!ack_i) begin
                        done_o <= 1'b1;
                        state  <= HM_IDLE;
                    end
                end
                default: state <= HM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_slave.sv
module hs_slave
    import hs_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ACK_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              req_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ready_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o
);
    ha_state_e  state;
    logic [1:0] mode_q;
    hs_policy_t pol;
    logic       tmr_run;
    logic       tmr_expire;

    assign pol     = hs_policy(mode_q);
    assign tmr_run = (state == HA_ACK) && !pol.waits_release;

    hs_hold_timer #(.HOLD(ACK_HOLD)) u_ack_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (tmr_run),
        .expire_o (tmr_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= HA_IDLE;
            ack_o      <= 1'b0;
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
            mode_q     <= HS_OPEN;
        end else begin
            rx_valid_o <= 1'b0;
            unique case (state)
                HA_IDLE: begin
                    if (req_i && ready_i) begin
                        ack_o      <= 1'b1;
                        rx_data_o  <= data_i;
                        rx_valid_o <= 1'b1;
                        mode_q     <= mode_i;
                        state      <= HA_ACK;
                    end
                end
                HA_ACK: begin
                    if (pol.waits_release) begin
                        if (!req_i) begin
                            ack_o <= 1'b0;
                            state <= HA_IDLE;
                        end
                    end else if (tmr_expire) begin
                        ack_o <= 1'b0;
                        state <= req_i ? HA_REARM : HA_IDLE;
                    end
                end
                HA_REARM: begin
                    if (!req_i) state <= HA_IDLE;
                end
                default: state <= HA_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_link.sv
module hs_link #(
    parameter int DATA_W   = 8,
    parameter int REQ_HOLD = 3,
    parameter int ACK_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              busy_o,
    output logic              done_o,
    input  logic              slv_ready_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              req_o,
    output logic              ack_o
);
    logic [DATA_W-1:0] bus_data;
    logic [1:0]        bus_mode;

    hs_master #(.DATA_W(DATA_W), .REQ_HOLD(REQ_HOLD)) u_master (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode_i),
        .start_i (start_i),
        .data_i  (tx_data_i),
        .ack_i   (ack_o),
        .req_o   (req_o),
        .data_o  (bus_data),
        .mode_o  (bus_mode),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    hs_slave #(.DATA_W(DATA_W), .ACK_HOLD(ACK_HOLD)) u_slave (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (bus_mode),
        .req_i      (req_o),
        .data_i     (bus_data),
        .ready_i    (slv_ready_i),
        .ack_o      (ack_o),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o)
    );
endmodule

// File: rtl/hs_link_checker.sv
module hs_link_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       rx_valid_o,
    input logic       req_o,
    input logic       ack_o
);
    logic [1:0] chk_mode;

    always_ff @(posedge clk) begin
        if (rst)          chk_mode <= 2'd0;
        else if (!busy_o) chk_mode <= mode_i;
    end

    // R2: request only rises while acknowledge is low
    a_r2_req_needs_quiet_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> !$past(ack_o));

    // R4: interlocked modes drop request only after acknowledge
    a_r4_req_fall_after_ack: assert property (@(posedge clk) disable iff (rst)
        ($fell(req_o) && chk_mode != 2'd0) |-> $past(ack_o));

    // R5: acknowledge only answers a live request
    a_r5_ack_answers_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> $past(req_o));

    // R5: receive pulse coincides with acknowledge rising
    a_r5_valid_with_ack: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> $rose(ack_o));

    // R7: locked mode releases acknowledge only after request is gone
    a_r7_locked_ack_release: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_o) && chk_mode[1]) |-> !$past(req_o));

    // R8: completion is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

bind hs_link hs_link_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rx_valid_o (rx_valid_o),
    .req_o      (req_o),
    .ack_o      (ack_o)
);

// File: tb/hs_link_bench.sv
module hs_link_bench;
    localparam int DW = 8;
    localparam int RH = 3;
    localparam int AH = 4;
    localparam int WIN = 25;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic          start = 1'b0;
    logic [DW-1:0] txd = '0;
    logic          ready = 1'b0;
    logic          busy, done, rxv, req, ack;
    logic [DW-1:0] rxd;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    hs_link #(.DATA_W(DW), .REQ_HOLD(RH), .ACK_HOLD(AH)) u_hs_link (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .start_i    (start),
        .tx_data_i  (txd),
        .busy_o     (busy),
        .done_o     (done),
        .slv_ready_i(ready),
        .rx_data_o  (rxd),
        .rx_valid_o (rxv),
        .req_o      (req),
        .ack_o      (ack)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // One transfer: mode m, receiver ready k cycles after request, extra start at xs (-1 none),
    // mode input flipped to open at t=1 when flip is set.
    task automatic run_txn(input logic [1:0] m, input int k, input logic [DW-1:0] d,
                           input int xs, input bit flip);
        int  t_ack_r = -1, t_ack_f = -1, t_req_f = -1, t_done = -1, t_rxv = -1;
        int  n_req_r = 0, n_done = 0, n_rxv = 0;
        bit  p_req = 1'b0, p_ack = 1'b0;
        bit  ack_en, locked, timed;
        int  e_req_f, e_done, e_ack_f;
        @(negedge clk);
        mode  = m;
        txd   = d;
        ready = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < WIN; t++) begin
            if (req && !p_req) n_req_r++;
            if (!req && p_req && t_req_f < 0) t_req_f = t;
            if (ack && !p_ack && t_ack_r < 0) t_ack_r = t;
            if (!ack && p_ack && t_ack_f < 0) t_ack_f = t;
            if (done) begin n_done++; if (t_done < 0) t_done = t; end
            if (rxv)  begin n_rxv++;  if (t_rxv < 0) t_rxv = t; end
            p_req = req;
            p_ack = ack;
            if (t == k) ready = 1'b1;
            start = (t == xs);
            if (flip && t == 1) mode = 2'd0;
            @(negedge clk);
        end
        ready = 1'b0;
        start = 1'b0;

        locked = m[1];
        timed  = !locked;
        ack_en = (m != 2'd0) || (k <= RH - 1);
        e_req_f = (m == 2'd0) ? RH : k + 2;
        e_done  = (m == 2'd0) ? RH : (locked ? k + 4 : k + 2);
        e_ack_f = !ack_en ? -1 : (timed ? k + 1 + AH : k + 3);

        check(n_req_r == 1, "R2 single request rise", n_req_r, 1);
        if (m == 2'd0) check(t_req_f == e_req_f, "R3 open req hold", t_req_f, e_req_f);
        else           check(t_req_f == e_req_f, "R4 req waits ack", t_req_f, e_req_f);
        check(t_ack_r == (ack_en ? k + 1 : -1), "R5 ack rise", t_ack_r, ack_en ? k + 1 : -1);
        check(t_rxv == (ack_en ? k + 1 : -1), "R5 rx_valid time", t_rxv, ack_en ? k + 1 : -1);
        check(n_rxv == (ack_en ? 1 : 0), "R5 rx_valid count", n_rxv, ack_en ? 1 : 0);
        if (ack_en) check(rxd == d, "R5 rx data", int'(rxd), int'(d));
        if (timed) check(t_ack_f == e_ack_f, "R6 timed ack release", t_ack_f, e_ack_f);
        else       check(t_ack_f == e_ack_f, "R7 locked ack release", t_ack_f, e_ack_f);
        check(t_done == e_done, "R8 done time", t_done, e_done);
        check(n_done == 1, "R8 done count", n_done, 1);
        if (m == 2'd3 || flip) check(t_done == e_done, "R9 mode decode/sampling", t_done, e_done);
        check(!busy && !req && !ack, "R2 idle after transfer", int'({busy, req, ack}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!req && !ack && !done && !busy && !rxv, "R1 reset state",
              int'({req, ack, done, busy, rxv}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!req && !ack && !done && !busy && !rxv, "R1 after release",
              int'({req, ack, done, busy, rxv}), 0);

        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 5; k++) begin
                run_txn(2'(m), k, 8'(8'hA5 ^ (k * 37 + m * 11)), -1, 1'b0);
            end
        end
        // R2: start while ack still high after open-mode completion is dropped
        run_txn(2'd0, 0, 8'h3C, RH, 1'b0);
        // R2 and R9: start while busy dropped; mode change mid-transfer ignored
        run_txn(2'd2, 2, 8'hC3, 1, 1'b1);
        run_txn(2'd1, 1, 8'h5A, 1, 1'b1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule